// File: doc/BRIEF.md
# Half-to-Single Float Widening Converter

This block widens one IEEE binary16 value into the binary32 value that is exactly equal to it. Every class of input is handled: signed zeros, denormals, normals, infinities and both kinds of NaN. Widening never loses precision, so the block does no rounding. A half-precision denormal becomes an ordinary binary32 normal. The block finds the position of the leading one in the fraction, adjusts the exponent to match, and shifts the fraction up until the leading one becomes the hidden bit.

NaN inputs keep their sign and payload. A quiet NaN passes through with no flag. A signalling NaN has its fraction MSB set, which makes it quiet, and raises the invalid flag alongside the result. Denormal inputs never raise any flag.

The input is qualified by a valid strobe. When the parameter `REG_OUT` is 1 (the default), the result, its valid and its flag are registered and appear one clock after the input is accepted. When `REG_OUT` is 0, the path is purely combinational.

Top module: `half_to_single_cvt`

## Requirements
- R1: For a normal input (exponent field 1..30 in bits 14:10, bias 15), the output keeps the sign in bit 31. The output exponent in bits 30:23 is the input exponent plus 112. The output fraction is the 10 input fraction bits followed by 13 zero bits.
- R2: An input with exponent 0 and fraction 0 gives a binary32 zero with the same sign: 0x0000 gives 0x00000000 and 0x8000 gives 0x80000000.
- R3: An input with exponent 0 and a nonzero fraction is converted to the exact binary32 normal. With k the number of leading zeros of the 10-bit fraction, the output exponent is 112 - k. The fraction is shifted left by k+1 (dropping the leading one) and padded with 13 zeros. For example, 0x0001 gives 0x33800000.
- R4: Exponent 31 with fraction 0 gives infinity with the same sign: 0x7C00 gives 0x7F800000 and 0xFC00 gives 0xFF800000.
- R5: Exponent 31 with fraction bit 9 set is a quiet NaN. The output is the sign, exponent 0xFF, and the 10-bit payload followed by 13 zeros. The invalid flag stays low.
- R6: Exponent 31 with fraction bit 9 clear and a nonzero fraction is a signalling NaN. The output is built as in R5, but with output bit 22 forced to 1, and the invalid flag is raised.
- R7: The invalid flag is raised for signalling NaN inputs and for nothing else, including denormal inputs.
- R8: With REG_OUT=1, a cycle with inValid high produces outValid high, with its result and flag, on the next clock edge. A cycle with inValid low produces outValid low on the next edge.
- R9: While inValid is low, outSingle keeps its previous value and outInvalid is low.
- R10: During reset, outValid, outInvalid and outSingle are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input value is present this cycle |
| inHalf | input | 16 | binary16 operand |
| outValid | output | 1 | Result is present |
| outSingle | output | 32 | binary32 result |
| outInvalid | output | 1 | Invalid-operation flag (signalling NaN input) |

## Verification
The bench covers the denormal range at both ends, the single lowest bit and the fraction with every bit set, as well as a mid-length leading-zero count. A design with an off-by-one in the leading-zero count would produce results off by a power of two, or leave the hidden bit in the fraction. Normal inputs at the smallest and largest exponents would expose a wrong rebias constant. Quiet and signalling NaNs of both signs with nonzero payloads are applied: a design that lost the payload, failed to set the quiet bit, or flagged quiet NaNs would show it in the output word or the flag. Idle cycles after a flagged result check that the flag does not linger and that the held result is not disturbed.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
  localparam int HALF_EXP_W  = 5;
  localparam int HALF_FRAC_W = 10;
  localparam int SGL_EXP_W   = 8;
  localparam int SGL_FRAC_W  = 23;
  localparam int HALF_W      = 1 + HALF_EXP_W + HALF_FRAC_W;
  localparam int SGL_W       = 1 + SGL_EXP_W + SGL_FRAC_W;
  localparam int HALF_BIAS   = (1 << (HALF_EXP_W - 1)) - 1;
  localparam int SGL_BIAS    = (1 << (SGL_EXP_W - 1)) - 1;
  localparam int BIAS_DELTA  = SGL_BIAS - HALF_BIAS;
  localparam int PAD_W       = SGL_FRAC_W - HALF_FRAC_W;
  localparam int LZ_W        = $clog2(HALF_FRAC_W + 1);

  typedef struct packed {
    logic signBit;
    logic zeroSel;
    logic denormSel;
    logic normalSel;
    logic specialSel;
    logic quietSet;
    logic raiseInvalid;
  } cvt_ctrl_t;
endpackage

// File: rtl/h2s_classify.sv
module h2s_classify
  import h2s_pkg::*;
(
  input  logic [HALF_W-1:0] halfIn,
  output cvt_ctrl_t         ctrl
);
  logic [HALF_EXP_W-1:0]  expField;
  logic [HALF_FRAC_W-1:0] fracField;
  logic expZero, expOnes, fracZero, fracTop;

  always_comb begin
    expField  = halfIn[HALF_W-2 -: HALF_EXP_W];
    fracField = halfIn[HALF_FRAC_W-1:0];
    expZero   = (expField == '0);
    expOnes   = (expField == '1);
    fracZero  = (fracField == '0);
    fracTop   = fracField[HALF_FRAC_W-1];

    ctrl.signBit      = halfIn[HALF_W-1];
    ctrl.zeroSel      = expZero && fracZero;
    ctrl.denormSel    = expZero && !fracZero;
    ctrl.normalSel    = !expZero && !expOnes;
    ctrl.specialSel   = expOnes;
    ctrl.quietSet     = expOnes && !fracZero;
    ctrl.raiseInvalid = expOnes && !fracZero && !fracTop;
  end
endmodule

// File: rtl/h2s_datapath.sv
module h2s_datapath
  import h2s_pkg::*;
(
  input  logic [HALF_W-1:0] halfIn,
  input  cvt_ctrl_t         ctrl,
  output logic [SGL_W-1:0]  singleOut
);
  logic [HALF_EXP_W-1:0]  expField;
  logic [HALF_FRAC_W-1:0] fracField;
  logic [LZ_W-1:0]        leadZeros;
  logic [HALF_FRAC_W-1:0] normFrac;
  logic [SGL_EXP_W-1:0]   resExp;
  logic [HALF_FRAC_W-1:0] resFrac;

  // leading-zero count: the highest set bit wins
  always_comb begin
    expField  = halfIn[HALF_W-2 -: HALF_EXP_W];
    fracField = halfIn[HALF_FRAC_W-1:0];
    leadZeros = LZ_W'(HALF_FRAC_W);
    for (int i = 0; i < HALF_FRAC_W; i++) begin
      if (fracField[i]) leadZeros = LZ_W'(HALF_FRAC_W - 1 - i);
    end
    normFrac = fracField << (leadZeros + LZ_W'(1));
  end

  always_comb begin
    resExp  = '0;
    resFrac = '0;
    if (ctrl.normalSel) begin
      resExp  = SGL_EXP_W'(expField) + SGL_EXP_W'(BIAS_DELTA);
      resFrac = fracField;
    end else if (ctrl.denormSel) begin
      resExp  = SGL_EXP_W'(BIAS_DELTA) - SGL_EXP_W'(leadZeros);
      resFrac = normFrac;
    end else if (ctrl.specialSel) begin
      resExp  = '1;
      resFrac = fracField;
      resFrac[HALF_FRAC_W-1] = fracField[HALF_FRAC_W-1] | ctrl.quietSet;
    end
    singleOut = {ctrl.signBit, resExp, resFrac, {PAD_W{1'b0}}};
  end

  // R3: a renormalized denormal lands inside the binary32 window of exponents 103..112
  always_comb begin
    if (ctrl.denormSel) begin
      assert_denorm_window_R3: assert (resExp >= SGL_EXP_W'(BIAS_DELTA - HALF_FRAC_W + 1)
                                       && resExp <= SGL_EXP_W'(BIAS_DELTA));
    end
  end
endmodule

// File: rtl/h2s_outstage.sv
module h2s_outstage
  import h2s_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SGL_W-1:0] resultIn,
  input  logic             invalidIn,
  output logic             outValid,
  output logic [SGL_W-1:0] outSingle,
  output logic             outInvalid
);
  generate
    if (REG_OUT) begin : gen_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          outValid   <= 1'b0;
          outSingle  <= '0;
          outInvalid <= 1'b0;
        end else begin
          outValid   <= inValid;
          outInvalid <= inValid && invalidIn;
          if (inValid) outSingle <= resultIn;
        end
      end

      assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      assert_idle_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);
      assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> ($stable(outSingle) && !outInvalid));
      assert_flag_means_quiet_nan_R6: assert property (@(posedge clk) disable iff (!rstN)
        outInvalid |-> (outValid && outSingle[SGL_W-2 -: SGL_EXP_W] == '1
                        && outSingle[SGL_FRAC_W-1]));
    end else begin : gen_comb
      always_comb begin
        outValid   = inValid;
        outSingle  = resultIn;
        outInvalid = inValid && invalidIn;
      end
    end
  endgenerate
endmodule

// File: rtl/half_to_single_cvt.sv
module half_to_single_cvt
  import h2s_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [15:0] inHalf,
  output logic        outValid,
  output logic [31:0] outSingle,
  output logic        outInvalid
);
  cvt_ctrl_t        ctrl;
  logic [SGL_W-1:0] result;

  h2s_classify u_classify (
    .halfIn (inHalf),
    .ctrl   (ctrl)
  );

  h2s_datapath u_datapath (
    .halfIn    (inHalf),
    .ctrl      (ctrl),
    .singleOut (result)
  );

  h2s_outstage #(.REG_OUT(REG_OUT)) u_outstage (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .resultIn   (result),
    .invalidIn  (ctrl.raiseInvalid),
    .outValid   (outValid),
    .outSingle  (outSingle),
    .outInvalid (outInvalid)
  );
endmodule

// File: tb/sim_half_to_single_cvt.sv
module sim_half_to_single_cvt;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 5000;

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] h;
    logic [31:0] s;
    logic        inv;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VEC [NVEC] = '{
    '{4'd1,  16'h3C00, 32'h3F800000, 1'b0},  // R1 one
    '{4'd1,  16'h5991, 32'h43322000, 1'b0},  // R1 178.125
    '{4'd1,  16'h7BFF, 32'h477FE000, 1'b0},  // R1 largest normal
    '{4'd1,  16'h0400, 32'h38800000, 1'b0},  // R1 smallest normal
    '{4'd1,  16'hC000, 32'hC0000000, 1'b0},  // R1 minus two
    '{4'd2,  16'h0000, 32'h00000000, 1'b0},  // R2 +0
    '{4'd2,  16'h8000, 32'h80000000, 1'b0},  // R2 -0
    '{4'd3,  16'h0001, 32'h33800000, 1'b0},  // R3 smallest denormal
    '{4'd3,  16'h8001, 32'hB3800000, 1'b0},  // R3 negative smallest
    '{4'd3,  16'h03FF, 32'h387FC000, 1'b0},  // R3 largest denormal
    '{4'd3,  16'h0200, 32'h38000000, 1'b0},  // R3 top bit only
    '{4'd3,  16'h0155, 32'h37AA8000, 1'b0},  // R3 one leading zero
    '{4'd7,  16'h8200, 32'hB8000000, 1'b0},  // R7 denormal raises nothing
    '{4'd4,  16'h7C00, 32'h7F800000, 1'b0},  // R4 +inf
    '{4'd4,  16'hFC00, 32'hFF800000, 1'b0},  // R4 -inf
    '{4'd5,  16'h7E00, 32'h7FC00000, 1'b0},  // R5 quiet NaN
    '{4'd5,  16'hFE01, 32'hFFC02000, 1'b0},  // R5 quiet NaN with payload
    '{4'd6,  16'h7C01, 32'h7FC02000, 1'b1},  // R6 signalling NaN
    '{4'd6,  16'hFD00, 32'hFFE00000, 1'b1},  // R6 negative signalling NaN
    '{4'd6,  16'h7DFF, 32'h7FFFE000, 1'b1}   // R6 all payload bits
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inHalf = '0;
  logic        outValid;
  logic [31:0] outSingle;
  logic        outInvalid;
  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  half_to_single_cvt u0 (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inHalf     (inHalf),
    .outValid   (outValid),
    .outSingle  (outSingle),
    .outInvalid (outInvalid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    // R10: reset state
    inHalf = 16'h7C01;
    inValid = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 outValid in reset", {31'd0, outValid}, 32'd0);
    check("R10 outSingle in reset", outSingle, 32'd0);
    check("R10 outInvalid in reset", {31'd0, outInvalid}, 32'd0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // table walk: drive at a falling edge, result appears after the next rising edge
    for (int i = 0; i < NVEC; i++) begin
      inHalf  = VEC[i].h;
      inValid = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d result of %h", VEC[i].req, VEC[i].h), outSingle, VEC[i].s);
      check($sformatf("R%0d flag of %h", VEC[i].req, VEC[i].h), {31'd0, outInvalid}, {31'd0, VEC[i].inv});
      check($sformatf("R8 valid after %h", VEC[i].h), {31'd0, outValid}, 32'd1);
    end

    // R9: idle after a flagged result; new data on the bus must be ignored
    held = outSingle;
    inValid = 1'b0;
    inHalf = 16'h3C00;
    @(negedge clk);
    check("R8 valid drops when idle", {31'd0, outValid}, 32'd0);
    check("R9 result held when idle", outSingle, held);
    check("R9 flag cleared when idle", {31'd0, outInvalid}, 32'd0);
    inHalf = 16'h7C01;
    @(negedge clk);
    check("R9 result still held", outSingle, held);
    check("R7 no flag without valid", {31'd0, outInvalid}, 32'd0);

    // R7: quiet NaN right after a signalling one clears the flag
    inHalf = 16'h7C02;
    inValid = 1'b1;
    @(negedge clk);
    check("R6 back-to-back sNaN flag", {31'd0, outInvalid}, 32'd1);
    check("R6 back-to-back sNaN result", outSingle, 32'h7FC04000);
    inHalf = 16'h7E00;
    @(negedge clk);
    check("R5 qNaN after sNaN flag", {31'd0, outInvalid}, 32'd0);
    check("R5 qNaN after sNaN result", outSingle, 32'h7FC00000);

    // R10: reset again mid-run
    rstN = 1'b0;
    @(negedge clk);
    check("R10 outSingle after re-reset", outSingle, 32'd0);
    check("R10 outValid after re-reset", {31'd0, outValid}, 32'd0);
    rstN = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule